// File: doc/BRIEF.md
# FIFO Flag-Offset Configuration Loader

This block sits next to a synchronous FIFO and fills in the two threshold offsets its flag logic needs. One is the almost-full distance (Y) and the other is the almost-empty distance (X). After a master reset the loader reads a pair of mode pins, which are latched at the last clock edge of reset. The mode picks one of three offset sources: a fixed preset of eight for both offsets, two qualified writes on the FIFO's write-port bus, or a serial bit stream with its own enable. Until both offsets are in place, the loader holds the FIFO's input-ready flag low. While that flag is low, write attempts do not reach the FIFO.

A partial reset returns the FIFO to empty but keeps the loaded offsets. Input-ready drops while the partial reset is held. It comes back one clock after release with no new configuration sequence. The offsets go straight to the flag comparators, which sit outside this block.

Top module: `ofl_loader`

## Requirements
- R1: While `rst_n` is low, `in_ready` is low and both `x_offset` and `y_offset` read zero. A master reset takes priority over a partial reset held at the same time.
- R2: The mode is taken from `mode_sel` at the last rising clock edge where `rst_n` is low. Encoding: 2'b00 is preset, 2'b01 is parallel, 2'b10 and 2'b11 are serial. Changes on `mode_sel` after that edge have no effect.
- R3: In preset mode, both offsets become 8 and `in_ready` goes high at the first clock edge after reset release. No other input is needed.
- R4: In parallel mode, a bus write counts as a qualified write only when `csel_n` is low, `wr_sel` is high, `mbox_sel` is low and `port_en` is high. Any other combination leaves both offsets and `in_ready` unchanged.
- R5: In parallel mode, the first qualified write loads `y_offset` from `wdata[10:0]` and the second loads `x_offset` from `wdata[10:0]`. `in_ready` is high after the edge of the second write.
- R6: In serial mode, `ser_data` is sampled only on edges where `ser_en` is high, most significant bit first. Bits 1 to 11 form Y and bits 12 to 22 form X. `in_ready` rises after the edge that takes the 22nd bit, not before.
- R7: `fifo_wr` is high exactly when a qualified write (as in R4) coincides with `in_ready` high. Writes made during configuration, including the one that completes it, do not produce `fifo_wr`.
- R8: While `prs_n` is low (with `rst_n` high), `in_ready` is low and both offsets keep their values. `in_ready` returns high at the first edge after `prs_n` goes back high if configuration had finished.
- R9: While `prs_n` is low, configuration inputs (serial bits and parallel offset writes) are not accepted.
- R10: While `in_ready` is high, `x_offset` and `y_offset` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| prs_n | input | 1 | Partial reset, synchronous, active low, keeps offsets |
| mode_sel | input | 2 | Offset source select, latched during master reset |
| ser_data | input | 1 | Serial offset bit |
| ser_en | input | 1 | Serial shift enable |
| csel_n | input | 1 | Write-port chip select, active low |
| wr_sel | input | 1 | Write/read direction, high for write |
| mbox_sel | input | 1 | Mailbox select, must be low for FIFO or offset writes |
| port_en | input | 1 | Write-port enable |
| wdata | input | 36 | Write-port data bus |
| in_ready | output | 1 | FIFO input-ready flag, low until configured |
| fifo_wr | output | 1 | Qualified write passed to the FIFO memory |
| x_offset | output | 11 | Almost-empty offset |
| y_offset | output | 11 | Almost-full offset |

## Verification
Each source mode is run after its own master reset, with `mode_sel` flipped right after release. A wrong mode latch therefore shows up as the wrong source being used. In parallel mode, each of the four qualifiers is violated one at a time before valid writes are made, which separates a missing qualifier term from a correct load. The serial stream uses asymmetric Y and X patterns with idle gaps and junk data on the gaps. This shows bit order, the Y/X split and gap handling as distinct failures. Partial resets are placed both after configuration and in the middle of a serial load, to tell "keep offsets" apart from "pause loading".

// File: rtl/ofl_pkg.sv
// Package: shared mode encoding for the flag-offset loader.
// Assumes a two-bit mode field; both codes with the top bit set mean serial.
package ofl_pkg;
    typedef enum logic [1:0] {
        OFL_PRESET   = 2'b00,
        OFL_PARALLEL = 2'b01,
        OFL_SERIAL   = 2'b10,
        OFL_SERIAL_B = 2'b11
    } ofl_mode_e;

    // True for either serial code.
    function automatic logic is_serial(input ofl_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/ofl_mode_capture.sv
// Module: ofl_mode_capture
// Latches the mode pins on every edge while master reset is low, so the value
// from the last reset edge is held afterwards. Assumes synchronous reset.
module ofl_mode_capture
    import ofl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] mode_pins,
    output ofl_mode_e mode_q
);
    // Follow the pins during reset, freeze once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ofl_mode_e'(mode_pins);
        end
    end
endmodule

// File: rtl/ofl_par_capture.sv
// Module: ofl_par_capture
// Takes two accepted bus words in order: slot 0 (Y) then slot 1 (X), each
// from the low bits of the bus. Assumes the caller gates `accept` with mode,
// partial reset and completion; cleared only by master reset.
module ofl_par_capture #(
    parameter int OFS_W = 11,
    parameter int BUS_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BUS_W-1:0] data,
    output logic [OFS_W-1:0] y_val,
    output logic [OFS_W-1:0] x_val,
    output logic             last
);
    localparam int NSLOT = 2;

    logic             idx;
    logic [OFS_W-1:0] slot [NSLOT];

    // Advance the slot index on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= 1'b0;
        else if (accept) idx <= 1'b1;
    end

    // One offset register per slot, loaded when its turn comes.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (accept && (idx == 1'(g)))
                slot[g] <= data[OFS_W-1:0];
        end
    end

    assign y_val = slot[0];
    assign x_val = slot[1];
    assign last  = accept && idx;
endmodule

// File: rtl/ofl_ser_shifter.sv
// Module: ofl_ser_shifter
// Shifts serial bits MSB first: the first OFS_W bits into Y, the next OFS_W
// into X. Assumes `accept` is already qualified with the shift enable.
module ofl_ser_shifter #(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             bit_in,
    output logic [OFS_W-1:0] y_val,
    output logic [OFS_W-1:0] x_val,
    output logic             last
);
    localparam int NBITS = 2 * OFS_W;
    localparam int CW    = $clog2(NBITS + 1);

    logic [CW-1:0] cnt;
    logic          in_y;

    assign in_y = (cnt < CW'(OFS_W));
    assign last = accept && (cnt == CW'(NBITS - 1));

    // Count accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (accept) cnt <= cnt + 1'b1;
    end

    // Shift into Y during the first half, into X during the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_val <= '0;
            x_val <= '0;
        end else if (accept) begin
            if (in_y) y_val <= {y_val[OFS_W-2:0], bit_in};
            else      x_val <= {x_val[OFS_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/ofl_loader.sv
// Module: ofl_loader (top)
// Loads the almost-full (Y) and almost-empty (X) offsets after master reset
// from the source chosen by the latched mode, and holds input-ready low until
// done. Partial reset drops input-ready but keeps the offsets. Assumes both
// resets are synchronous and active low; master reset has priority.
module ofl_loader
    import ofl_pkg::*;
#(
    parameter int OFS_W      = 11,
    parameter int BUS_W      = 36,
    parameter int PRESET_VAL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prs_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_data,
    input  logic             ser_en,
    input  logic             csel_n,
    input  logic             wr_sel,
    input  logic             mbox_sel,
    input  logic             port_en,
    input  logic [BUS_W-1:0] wdata,
    output logic             in_ready,
    output logic             fifo_wr,
    output logic [OFS_W-1:0] x_offset,
    output logic [OFS_W-1:0] y_offset
);
    localparam logic [OFS_W-1:0] PRESET_OFS = OFS_W'(PRESET_VAL);

    ofl_mode_e        mode_q;
    logic             cfg_done;
    logic             loading;
    logic             bus_qual;
    logic             par_acc, ser_acc, preset_hit;
    logic             par_last, ser_last, done_set;
    logic [OFS_W-1:0] par_y, par_x, ser_y, ser_x;

    ofl_mode_capture u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pins (mode_sel),
        .mode_q    (mode_q)
    );

    assign bus_qual   = !csel_n && wr_sel && !mbox_sel && port_en;
    assign loading    = prs_n && !cfg_done;
    assign par_acc    = loading && (mode_q == OFL_PARALLEL) && bus_qual;
    assign ser_acc    = loading && is_serial(mode_q) && ser_en;
    assign preset_hit = loading && (mode_q == OFL_PRESET);
    assign done_set   = preset_hit || par_last || ser_last;

    ofl_par_capture #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (par_acc),
        .data   (wdata),
        .y_val  (par_y),
        .x_val  (par_x),
        .last   (par_last)
    );

    ofl_ser_shifter #(.OFS_W(OFS_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (ser_acc),
        .bit_in (ser_data),
        .y_val  (ser_y),
        .x_val  (ser_x),
        .last   (ser_last)
    );

    // Remember that configuration finished; only master reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_done <= 1'b0;
        else if (done_set) cfg_done <= 1'b1;
    end

    // Input-ready: low in either reset, high once configuration is complete.
    always_ff @(posedge clk) begin
        if (!rst_n || !prs_n) in_ready <= 1'b0;
        else                  in_ready <= cfg_done || done_set;
    end

    // Choose the offset source for the latched mode.
    always_comb begin
        unique case (mode_q)
            OFL_PRESET: begin
                x_offset = cfg_done ? PRESET_OFS : '0;
                y_offset = cfg_done ? PRESET_OFS : '0;
            end
            OFL_PARALLEL: begin
                x_offset = par_x;
                y_offset = par_y;
            end
            default: begin
                x_offset = ser_x;
                y_offset = ser_y;
            end
        endcase
    end

    assign fifo_wr = bus_qual && in_ready;
endmodule

// Checker: temporal properties of the loader's ports and mode latch.
module ofl_loader_chk #(
    parameter int OFS_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prs_n,
    input logic             in_ready,
    input logic             fifo_wr,
    input logic [OFS_W-1:0] x_offset,
    input logic [OFS_W-1:0] y_offset,
    input logic [1:0]       mode_q
);
    assert_ready_low_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !in_ready);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    assert_wr_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> in_ready);

    assert_partial_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prs_n |=> !in_ready);

    assert_partial_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prs_n |=> ($stable(x_offset) && $stable(y_offset)));

    assert_offsets_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> ($stable(x_offset) && $stable(y_offset)));
endmodule

bind ofl_loader ofl_loader_chk #(.OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prs_n    (prs_n),
    .in_ready (in_ready),
    .fifo_wr  (fifo_wr),
    .x_offset (x_offset),
    .y_offset (y_offset),
    .mode_q   (mode_q)
);

// File: tb/tb_ofl_loader.sv
// Bench for ofl_loader: behavioural reference model compared each clock,
// plus directed checks per requirement.
module tb_ofl_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, prs_n = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        ser_data = 1'b0, ser_en = 1'b0;
    logic        csel_n = 1'b1, wr_sel = 1'b0, mbox_sel = 1'b0, port_en = 1'b0;
    logic [35:0] wdata = '0;
    logic        in_ready, fifo_wr;
    logic [10:0] x_offset, y_offset;

    int total = 0, bad = 0;
    int cycles = 0;
    bit cmp_on = 0;

    // reference model state
    int m_mode = 0, m_done = 0, m_ready = 0, m_x = 0, m_y = 0, m_cnt = 0;

    always #5 clk = ~clk;

    ofl_loader dut (
        .clk(clk), .rst_n(rst_n), .prs_n(prs_n), .mode_sel(mode_sel),
        .ser_data(ser_data), .ser_en(ser_en), .csel_n(csel_n), .wr_sel(wr_sel),
        .mbox_sel(mbox_sel), .port_en(port_en), .wdata(wdata),
        .in_ready(in_ready), .fifo_wr(fifo_wr),
        .x_offset(x_offset), .y_offset(y_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int qual();
        return (!csel_n && wr_sel && !mbox_sel && port_en) ? 1 : 0;
    endfunction

    // Reference model update on each edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = mode_sel; m_done = 0; m_ready = 0;
            m_x = 0; m_y = 0; m_cnt = 0;
        end else begin
            if (prs_n && !m_done) begin
                if (m_mode == 0) begin
                    m_x = 8; m_y = 8; m_done = 1;
                end else if (m_mode == 1 && qual() == 1) begin
                    if (m_cnt == 0) m_y = wdata[10:0];
                    else begin m_x = wdata[10:0]; m_done = 1; end
                    m_cnt++;
                end else if (m_mode >= 2 && ser_en) begin
                    if (m_cnt < 11) m_y = (m_y * 2 + ser_data) % 2048;
                    else            m_x = (m_x * 2 + ser_data) % 2048;
                    m_cnt++;
                    if (m_cnt == 22) m_done = 1;
                end
            end
            m_ready = prs_n ? m_done : 0;
        end
    end

    // Per-cycle comparison away from the edge.
    always begin
        @(negedge clk);
        #2;
        if (cmp_on) begin
            chk("R3 in_ready model", int'(in_ready), m_ready);
            chk("R5 x_offset model", int'(x_offset), m_x);
            chk("R6 y_offset model", int'(y_offset), m_y);
            chk("R7 fifo_wr model", int'(fifo_wr), (qual() == 1 && m_ready == 1) ? 1 : 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_idle;
        csel_n = 1'b1; wr_sel = 1'b0; mbox_sel = 1'b0; port_en = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; mode_sel = m;
        tick; tick;
        chk("R1 ready in reset", int'(in_ready), 0);
        chk("R1 x in reset", int'(x_offset), 0);
        chk("R1 y in reset", int'(y_offset), 0);
        rst_n = 1'b1; mode_sel = ~m;
        tick;
    endtask

    task automatic bus_wr(input logic cs_n, input logic wr, input logic mb,
                          input logic en, input logic [35:0] d);
        csel_n = cs_n; wr_sel = wr; mbox_sel = mb; port_en = en; wdata = d;
        tick;
        bus_idle;
    endtask

    task automatic sbit(input logic b, input bit gap);
        if (gap) begin
            ser_en = 1'b0; ser_data = ~b; tick;
        end
        ser_en = 1'b1; ser_data = b; tick;
        ser_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        tick;
        cmp_on = 1;

        // Preset mode
        do_reset(2'b00);
        chk("R3 preset x", int'(x_offset), 8);
        chk("R3 preset y", int'(y_offset), 8);
        chk("R2 preset kept despite pins", int'(in_ready), 1);
        bus_wr(1'b0, 1'b1, 1'b0, 1'b1, 36'h0_0000_0123);
        chk("R10 preset offsets unchanged by write", int'(y_offset), 8);

        // Parallel mode
        do_reset(2'b01);
        bus_wr(1'b1, 1'b1, 1'b0, 1'b1, 36'h111);
        bus_wr(1'b0, 1'b0, 1'b0, 1'b1, 36'h222);
        bus_wr(1'b0, 1'b1, 1'b1, 1'b1, 36'h333);
        bus_wr(1'b0, 1'b1, 1'b0, 1'b0, 36'h444);
        chk("R4 unqualified writes ignored y", int'(y_offset), 0);
        chk("R4 unqualified writes ignored ready", int'(in_ready), 0);
        csel_n = 1'b0; wr_sel = 1'b1; port_en = 1'b1; wdata = 36'hF_0000_0D5A;
        #1 chk("R7 no fifo_wr during config", int'(fifo_wr), 0);
        tick;
        chk("R5 first write to y", int'(y_offset), 'h55A);
        chk("R5 not ready after one", int'(in_ready), 0);
        wdata = 36'hA_5A5A_A0C3;
        #1 chk("R7 completing write not passed", int'(fifo_wr), 0);
        tick;
        chk("R5 second write to x", int'(x_offset), 'h0C3);
        chk("R5 ready after second", int'(in_ready), 1);
        wdata = 36'h0_0000_0077;
        #1 chk("R7 data write passed", int'(fifo_wr), 1);
        tick;
        chk("R10 x unchanged after data", int'(x_offset), 'h0C3);
        bus_idle;

        // Partial reset after configuration
        prs_n = 1'b0; tick;
        chk("R8 ready low in partial", int'(in_ready), 0);
        csel_n = 1'b0; wr_sel = 1'b1; port_en = 1'b1; wdata = 36'h7FF;
        #1 chk("R8 no fifo_wr in partial", int'(fifo_wr), 0);
        tick; bus_idle; tick;
        chk("R9 y kept", int'(y_offset), 'h55A);
        chk("R8 x kept", int'(x_offset), 'h0C3);
        prs_n = 1'b1; tick;
        chk("R8 ready back", int'(in_ready), 1);

        // Serial mode with gaps, partial reset mid-load
        do_reset(2'b10);
        for (int i = 10; i >= 0; i--) sbit(11'h5A3 >> i & 1, (i % 3) == 0);
        chk("R6 y after 11 bits", int'(y_offset), 'h5A3);
        for (int i = 10; i >= 6; i--) sbit(11'h01F >> i & 1, 0);
        prs_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            ser_en = 1'b1; ser_data = 1'b1; tick;
        end
        ser_en = 1'b0; prs_n = 1'b1; tick;
        chk("R9 serial paused in partial", int'(x_offset), 0);
        for (int i = 5; i >= 1; i--) sbit(11'h01F >> i & 1, i == 3);
        chk("R6 not ready before last bit", int'(in_ready), 0);
        sbit(1'b1, 0);
        chk("R6 x after 22 bits", int'(x_offset), 'h01F);
        chk("R6 ready after 22 bits", int'(in_ready), 1);
        sbit(1'b0, 0);
        chk("R10 extra serial bit ignored", int'(x_offset), 'h01F);

        // Alternate serial code and master-over-partial priority
        do_reset(2'b11);
        sbit(1'b1, 0);
        chk("R2 code 11 is serial", int'(y_offset), 1);
        prs_n = 1'b0; rst_n = 1'b0; tick;
        chk("R1 master priority y", int'(y_offset), 0);
        chk("R1 master priority ready", int'(in_ready), 0);
        prs_n = 1'b1; rst_n = 1'b1; tick; tick;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule